// File: doc/BRIEF.md
# Byte-Programmed SPI Master Sequencer

This block is a half-duplex SPI master whose transfers are described by a small program instead of a single start command. Software writes a 64-bit program word that holds eight one-byte opcodes. The block runs the opcodes starting with the most significant byte. An opcode can drive a chip select, shift a counted number of bytes out of a 64-bit transmit word, or shift a counted number of bytes into a 64-bit receive word. Each shift opcode waits on a full flag, so software can pace long transfers one 8-byte word at a time.

Software reaches the block through a register port that has a write strobe, a read strobe, a 4-bit address and 64-bit data. The registers are: program at address 0, transmit word at 1, receive word at 2, clock configuration at 3, counter configuration at 4 and status at 5. Reads are combinational within the strobe cycle. A read of the receive word changes flags at the following clock edge. The serial side uses SPI mode 0: SCK idles low, MISO is sampled on the rising edge, MOSI changes on the falling edge, and bytes go most significant bit first. The chip-select lines are active low.

Top module: `spi_prog_master`

## Requirements
- R1: After a write to address 0 while the block is idle, opcodes run from bits 63:56 downward. Execution stops at opcode 0x00 or after the eighth opcode. Status bits 55:48 read 0x01 when idle, 0x02 while decoding, 0x04 while waiting for transmit data, 0x08 while shifting out, 0x10 while waiting for receive space and 0x20 while shifting in.
- R2: Opcode 0x1n with 1 ≤ n ≤ N_CS drives chip select n-1 low and all others high. Opcode 0x10 drives every chip select high. A stop opcode leaves the chip selects unchanged.
- R3: Opcode 0x3n with 1 ≤ n ≤ 8 sends n bytes of the transmit word (address 1), starting from bits 63:56. Bits go MSB first in SPI mode 0.
- R4: Opcode 0x4n with 1 ≤ n ≤ 8 receives n bytes into the receive word (address 2). The result is right-aligned: the last bit received lands in bit 0 and all unused upper bits are zero.
- R5: Status bit 59 (transmit full) sets when the transmit word is written and clears when a shift-out opcode takes the word. A shift-out opcode waits with SCK low until bit 59 is set.
- R6: Status bit 63 (receive full) sets when a shift-in completes and clears when the receive word is read. A shift-in opcode waits with SCK low while bit 63 is set.
- R7: A write to the transmit word while it is full sets bit 58 and the write is discarded. A read of the receive word while it is empty sets bit 61.
- R8: A write to status (address 5) clears each of bits 58 and 61 whose written bit is 0 and leaves it alone if the written bit is 1. The write does not change the full flags.
- R9: SCK has a period of 2·(D+1) system clocks, where D is clock configuration bits 63:52.
- R10: A write to address 3 with bits 39:36 = 0101 followed directly by a write to address 3 with bits 39:36 = 1010 performs a soft reset. The sequencer returns to idle, all chip selects go high and both full flags clear. Neither write changes the stored configuration, and the first write alone has no effect.
- R11: Opcodes not covered by R1–R4 are no-ops: 0x3n or 0x4n with n = 0 or n > 8, 0xCn, 0xEn, and others.
- R12: A write to address 0 while the sequencer is not idle is ignored, and the program word reads back unchanged.
- R13: After reset, status reads 0x0001_0000_0000_0000, all chip selects are high, SCK and MOSI are low, and the clock configuration reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | N_CS | Chip selects, active low |

## Verification
The in-line assertions check these properties on every cycle:
- At most one chip select is low.
- SCK moves only on a divider tick and is low whenever no shift is active.
- A shift-in only starts and stores into an empty receive word.
- Taking the transmit word clears its flag.
- A write to a full transmit word raises overrun.
- A soft reset lands in idle.
- The program word is unchanged after a write that arrives while the sequencer is busy.

Other behaviour shows only through the bench's scenarios with a modelled SPI slave:
- the bit order and right alignment of data on the wire;
- the measured SCK period at two divider settings;
- stalls that hold until software supplies data or drains data;
- no-op opcodes;
- stop versus the eighth-opcode end;
- the two-step reset.

// File: rtl/spi_prog_pkg.sv
package spi_prog_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_DECODE, S_TX_WAIT, S_TX_SHIFT, S_RX_WAIT, S_RX_SHIFT
  } seq_state_e;

  localparam logic [3:0] ADDR_PROG = 4'd0;
  localparam logic [3:0] ADDR_TX   = 4'd1;
  localparam logic [3:0] ADDR_RX   = 4'd2;
  localparam logic [3:0] ADDR_CLK  = 4'd3;
  localparam logic [3:0] ADDR_CNT  = 4'd4;
  localparam logic [3:0] ADDR_STAT = 4'd5;

  localparam int ST_RX_FULL = 63;
  localparam int ST_RX_UDR  = 61;
  localparam int ST_TX_FULL = 59;
  localparam int ST_TX_OVR  = 58;
  localparam int ST_CODE_LO = 48;

  localparam logic [3:0] RST_STEP1 = 4'b0101;
  localparam logic [3:0] RST_STEP2 = 4'b1010;

  function automatic logic [7:0] state_code(seq_state_e s);
    case (s)
      S_IDLE:     return 8'h01;
      S_DECODE:   return 8'h02;
      S_TX_WAIT:  return 8'h04;
      S_TX_SHIFT: return 8'h08;
      S_RX_WAIT:  return 8'h10;
      S_RX_SHIFT: return 8'h20;
      default:    return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/spi_prog_clkdiv.sv
module spi_prog_clkdiv #(
  parameter int DIV_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;

  // one tick per half period of div_i+1 cycles
  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  a_r9_count_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_o) |=> (cnt_q == '0));

endmodule

// File: rtl/spi_prog_shifter.sv
module spi_prog_shifter #(
  parameter int WORD_W = 64,
  parameter int NB_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic [NB_W-1:0]   nbytes_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);

  localparam int BIT_W = $clog2(WORD_W + 1);

  logic              busy_q, done_q, sck_q;
  logic [BIT_W-1:0]  bits_q;
  logic [WORD_W-1:0] tx_sr_q, rx_sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      sck_q   <= 1'b0;
      bits_q  <= '0;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      bits_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q  <= 1'b1;
        sck_q   <= 1'b0;
        bits_q  <= BIT_W'(nbytes_i) << 3;
        tx_sr_q <= tx_word_i;
        rx_sr_q <= '0;
      end else if (busy_q && tick_i) begin
        if (!sck_q) begin
          sck_q   <= 1'b1;
          rx_sr_q <= {rx_sr_q[WORD_W-2:0], miso_i};
        end else begin
          sck_q   <= 1'b0;
          tx_sr_q <= {tx_sr_q[WORD_W-2:0], 1'b0};
          bits_q  <= bits_q - 1'b1;
          if (bits_q == BIT_W'(1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign sck_o     = sck_q;
  assign mosi_o    = busy_q & tx_sr_q[WORD_W-1];
  assign rx_word_o = rx_sr_q;

  a_r3_sck_low_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !sck_q);
  a_r3_done_ends_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!sck_q && !busy_q));

endmodule

// File: rtl/spi_prog_seq.sv
module spi_prog_seq
  import spi_prog_pkg::*;
#(
  parameter int N_CS   = 4,
  parameter int WORD_W = 64,
  parameter int NB_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] prog_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic              shift_done_i,
  output logic              start_o,
  output logic              dir_rx_o,
  output logic [NB_W-1:0]   nbytes_o,
  output logic              tx_take_o,
  output logic              rx_store_o,
  output logic              idle_o,
  output logic [7:0]        state_code_o,
  output logic [N_CS-1:0]   cs_no
);

  localparam int N_OPS = WORD_W / 8;
  localparam int IDX_W = $clog2(N_OPS);
  localparam int MAX_N = 8;

  seq_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [NB_W-1:0]   nbytes_q;
  logic [N_CS-1:0]   cs_q;
  logic [7:0]        op;
  logic              last_op, cnt_ok;

  // first opcode sits in the top byte
  assign op      = prog_i[{~idx_q, 3'b000} +: 8];
  assign last_op = (idx_q == IDX_W'(N_OPS - 1));
  assign cnt_ok  = (op[3:0] != 4'd0) && (op[3:0] <= 4'(MAX_N));

  assign tx_take_o    = (state_q == S_TX_WAIT) && tx_full_i;
  assign start_o      = tx_take_o || ((state_q == S_RX_WAIT) && !rx_full_i);
  assign dir_rx_o     = (state_q == S_RX_WAIT);
  assign nbytes_o     = nbytes_q;
  assign rx_store_o   = (state_q == S_RX_SHIFT) && shift_done_i;
  assign idle_o       = (state_q == S_IDLE);
  assign state_code_o = state_code(state_q);
  assign cs_no        = cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      idx_q    <= '0;
      nbytes_q <= '0;
      cs_q     <= '1;
    end else if (abort_i) begin
      state_q <= S_IDLE;
      idx_q   <= '0;
      cs_q    <= '1;
    end else begin
      case (state_q)
        S_IDLE: if (load_i) begin
          state_q <= S_DECODE;
          idx_q   <= '0;
        end
        S_DECODE: begin
          if (op == 8'h00) begin
            state_q <= S_IDLE;
            idx_q   <= '0;
          end else if (op[7:4] == 4'h3 && cnt_ok) begin
            nbytes_q <= NB_W'(op[3:0]);
            state_q  <= S_TX_WAIT;
          end else if (op[7:4] == 4'h4 && cnt_ok) begin
            nbytes_q <= NB_W'(op[3:0]);
            state_q  <= S_RX_WAIT;
          end else begin
            if (op[7:4] == 4'h1 && op[3:0] <= 4'(N_CS)) begin
              for (int i = 0; i < N_CS; i++) cs_q[i] <= (op[3:0] != 4'(i + 1));
            end
            state_q <= last_op ? S_IDLE : S_DECODE;
            idx_q   <= idx_q + 1'b1;
          end
        end
        S_TX_WAIT: if (tx_full_i) state_q <= S_TX_SHIFT;
        S_RX_WAIT: if (!rx_full_i) state_q <= S_RX_SHIFT;
        S_TX_SHIFT, S_RX_SHIFT: if (shift_done_i) begin
          state_q <= last_op ? S_IDLE : S_DECODE;
          idx_q   <= idx_q + 1'b1;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r2_one_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_q));
  a_r5_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni || abort_i)
    (state_q == S_TX_WAIT && !tx_full_i) |=> (state_q == S_TX_WAIT));
  a_r6_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni || abort_i)
    (state_q == S_RX_WAIT && rx_full_i) |=> (state_q == S_RX_WAIT));

endmodule

// File: rtl/spi_prog_master.sv
module spi_prog_master
  import spi_prog_pkg::*;
#(
  parameter int N_CS  = 4,
  parameter int DIV_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic            reg_re_i,
  input  logic [3:0]      reg_addr_i,
  input  logic [63:0]     reg_wdata_i,
  output logic [63:0]     reg_rdata_o,
  output logic            sck_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic [N_CS-1:0] cs_no
);

  localparam int WORD_W = 64;
  localparam int NB_W   = 4;
  localparam int DIV_LO = WORD_W - DIV_W;

  logic [WORD_W-1:0] prog_q, tx_q, rx_q, clk_cfg_q, cnt_cfg_q;
  logic tx_full_q, rx_full_q, tx_ovr_q, rx_udr_q, rst_arm_q;

  logic wr_prog, wr_tx, wr_clk, wr_cnt, wr_stat, rd_rx;
  logic rst_step1, soft_rst;
  logic seq_start, seq_dir_rx, seq_tx_take, seq_rx_store, seq_idle;
  logic [NB_W-1:0] seq_nbytes;
  logic [7:0] seq_code;
  logic sh_busy, sh_done, sh_sck, div_tick;
  logic [WORD_W-1:0] sh_rx_word;

  assign wr_prog = reg_we_i && reg_addr_i == ADDR_PROG;
  assign wr_tx   = reg_we_i && reg_addr_i == ADDR_TX;
  assign wr_clk  = reg_we_i && reg_addr_i == ADDR_CLK;
  assign wr_cnt  = reg_we_i && reg_addr_i == ADDR_CNT;
  assign wr_stat = reg_we_i && reg_addr_i == ADDR_STAT;
  assign rd_rx   = reg_re_i && reg_addr_i == ADDR_RX;

  assign rst_step1 = wr_clk && reg_wdata_i[39:36] == RST_STEP1;
  assign soft_rst  = wr_clk && rst_arm_q && reg_wdata_i[39:36] == RST_STEP2;

  spi_prog_seq #(.N_CS(N_CS), .WORD_W(WORD_W), .NB_W(NB_W)) u_seq (
    .clk_i, .rst_ni,
    .abort_i      (soft_rst),
    .load_i       (wr_prog),
    .prog_i       (prog_q),
    .tx_full_i    (tx_full_q),
    .rx_full_i    (rx_full_q),
    .shift_done_i (sh_done),
    .start_o      (seq_start),
    .dir_rx_o     (seq_dir_rx),
    .nbytes_o     (seq_nbytes),
    .tx_take_o    (seq_tx_take),
    .rx_store_o   (seq_rx_store),
    .idle_o       (seq_idle),
    .state_code_o (seq_code),
    .cs_no        (cs_no)
  );

  spi_prog_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni,
    .run_i  (sh_busy),
    .div_i  (clk_cfg_q[WORD_W-1:DIV_LO]),
    .tick_o (div_tick)
  );

  spi_prog_shifter #(.WORD_W(WORD_W), .NB_W(NB_W)) u_shift (
    .clk_i, .rst_ni,
    .abort_i   (soft_rst),
    .start_i   (seq_start),
    .nbytes_i  (seq_nbytes),
    .tx_word_i (seq_dir_rx ? '0 : tx_q),
    .tick_i    (div_tick),
    .miso_i    (miso_i),
    .busy_o    (sh_busy),
    .done_o    (sh_done),
    .sck_o     (sh_sck),
    .mosi_o    (mosi_o),
    .rx_word_o (sh_rx_word)
  );

  assign sck_o = sh_sck;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_q    <= '0;
      tx_q      <= '0;
      rx_q      <= '0;
      clk_cfg_q <= '0;
      cnt_cfg_q <= '0;
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
      tx_ovr_q  <= 1'b0;
      rx_udr_q  <= 1'b0;
      rst_arm_q <= 1'b0;
    end else begin
      if (wr_prog && seq_idle) prog_q <= reg_wdata_i;
      if (wr_cnt) cnt_cfg_q <= reg_wdata_i;

      // two-step soft reset; reset patterns never land in the config
      if (wr_clk) begin
        rst_arm_q <= rst_step1;
        if (!rst_step1 && !soft_rst) clk_cfg_q <= reg_wdata_i;
      end

      if (wr_tx && !tx_full_q) tx_q <= reg_wdata_i;
      if (soft_rst)                   tx_full_q <= 1'b0;
      else if (seq_tx_take)           tx_full_q <= 1'b0;
      else if (wr_tx)                 tx_full_q <= 1'b1;

      if (seq_rx_store) rx_q <= sh_rx_word;
      if (soft_rst)                   rx_full_q <= 1'b0;
      else if (seq_rx_store)          rx_full_q <= 1'b1;
      else if (rd_rx)                 rx_full_q <= 1'b0;

      if (wr_tx && tx_full_q)         tx_ovr_q <= 1'b1;
      else if (wr_stat)               tx_ovr_q <= tx_ovr_q & reg_wdata_i[ST_TX_OVR];

      if (rd_rx && !rx_full_q)        rx_udr_q <= 1'b1;
      else if (wr_stat)               rx_udr_q <= rx_udr_q & reg_wdata_i[ST_RX_UDR];
    end
  end

  logic [63:0] status;
  always_comb begin
    status = '0;
    status[ST_RX_FULL] = rx_full_q;
    status[ST_RX_UDR]  = rx_udr_q;
    status[ST_TX_FULL] = tx_full_q;
    status[ST_TX_OVR]  = tx_ovr_q;
    status[ST_CODE_LO +: 8] = seq_code;
  end

  always_comb begin
    case (reg_addr_i)
      ADDR_PROG: reg_rdata_o = prog_q;
      ADDR_TX:   reg_rdata_o = tx_q;
      ADDR_RX:   reg_rdata_o = rx_q;
      ADDR_CLK:  reg_rdata_o = clk_cfg_q;
      ADDR_CNT:  reg_rdata_o = cnt_cfg_q;
      ADDR_STAT: reg_rdata_o = status;
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r5_take_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_tx_take |=> !tx_full_q);
  a_r6_store_into_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_rx_store |-> !rx_full_q);
  a_r6_start_rx_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seq_start && seq_dir_rx) |-> !rx_full_q);
  a_r7_tx_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx && tx_full_q) |=> tx_ovr_q);
  a_r9_sck_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst)
    !div_tick |=> $stable(sh_sck));
  a_r10_reset_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst |=> (seq_idle && !tx_full_q && cs_no == '1));
  a_r12_prog_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_prog && !seq_idle) |=> $stable(prog_q));

endmodule

// File: tb/spi_prog_master_test.sv
`timescale 1ns/1ps
module spi_prog_master_test;

  localparam logic [3:0] A_PROG = 4'd0, A_TX = 4'd1, A_RX = 4'd2,
                         A_CLK = 4'd3, A_STAT = 4'd5;
  localparam logic [63:0] IDLE_ST = 64'h0001_0000_0000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [3:0]  addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic sck, mosi, miso;
  logic [3:0] cs_n;

  int n_chk = 0, n_fail = 0;
  logic [127:0] slv_sr = '0;
  logic [127:0] mosi_cap = '0;
  int rise_cnt = 0;
  realtime t_prev = 0, t_last = 0;

  always #5 clk = ~clk;

  spi_prog_master uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n)
  );

  // mode-0 slave model
  assign miso = slv_sr[127];
  always @(negedge sck) slv_sr = slv_sr << 1;
  logic [3:0] cs_at_sck = 4'hF;
  always @(posedge sck) begin
    mosi_cap = {mosi_cap[126:0], mosi};
    rise_cnt = rise_cnt + 1;
    t_prev = t_last;
    t_last = $realtime;
    cs_at_sck = cs_n;
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(A_STAT, s);
      if (s[55:48] == 8'h01) break;
    end
  endtask

  task automatic clr_mon();
    rise_cnt = 0; mosi_cap = '0;
  endtask

  task automatic t_reset();
    logic [63:0] s;
    rd(A_STAT, s);
    chk(s == IDLE_ST, "R13 status", s, IDLE_ST);
    chk(cs_n == 4'hF && sck == 1'b0 && mosi == 1'b0, "R13 pins", {cs_n, sck, mosi}, {4'hF, 2'b00});
    rd(A_CLK, s);
    chk(s == 64'h0, "R13 clkcfg", s, 0);
  endtask

  task automatic t_tx();
    logic [63:0] s;
    wr(A_CLK, {12'd2, 52'd0});
    wr(A_TX, 64'hA1B2C3_0000000000);
    rd(A_STAT, s);
    chk(s[59] == 1'b1, "R5 tx full set", s, 1);
    clr_mon();
    wr(A_PROG, 64'h11_33_10_00_0000_0000);
    wait_idle();
    chk(rise_cnt == 24, "R3 bit count", rise_cnt, 24);
    chk(mosi_cap[23:0] == 24'hA1B2C3, "R3 mosi bytes", mosi_cap[23:0], 24'hA1B2C3);
    chk(cs_at_sck == 4'b1110, "R2 cs0 low", cs_at_sck, 4'b1110);
    chk(cs_n == 4'hF, "R2 deselect", cs_n, 4'hF);
    rd(A_STAT, s);
    chk(s[59] == 1'b0, "R5 tx full cleared", s, 0);
    chk((t_last - t_prev) == 60.0, "R9 period div2", int'(t_last - t_prev), 60);
  endtask

  task automatic t_rx();
    logic [63:0] s;
    wr(A_CLK, 64'h0);
    wr(A_TX, 64'h96_00000000000000);
    slv_sr = {8'hFF, 16'h5A3C, 104'h0};
    clr_mon();
    wr(A_PROG, 64'h12_31_42_10_00_000000);
    wait_idle();
    chk(cs_at_sck == 4'b1101, "R2 cs1 low", cs_at_sck, 4'b1101);
    chk((t_last - t_prev) == 20.0, "R9 period div0", int'(t_last - t_prev), 20);
    rd(A_STAT, s);
    chk(s[63] == 1'b1, "R6 rx full set", s, 1);
    rd(A_RX, s);
    chk(s == 64'h5A3C, "R4 right aligned", s, 64'h5A3C);
    rd(A_STAT, s);
    chk(s[63] == 1'b0 && s[61] == 1'b0, "R6 rx full cleared", s[63:56], 0);
    rd(A_RX, s);
    rd(A_STAT, s);
    chk(s[61] == 1'b1, "R7 rx underrun", s, 1);
    wr(A_STAT, 64'h0);
    rd(A_STAT, s);
    chk(s == IDLE_ST, "R8 clear udr", s, IDLE_ST);
  endtask

  task automatic t_ovr();
    logic [63:0] s;
    wr(A_TX, 64'h11_00000000000000);
    wr(A_TX, 64'h22_00000000000000);
    rd(A_STAT, s);
    chk(s[59] && s[58], "R7 tx overrun", s[63:56], 8'h0C);
    wr(A_STAT, 64'h1 << 58);
    rd(A_STAT, s);
    chk(s[58] == 1'b1, "R8 keep when 1", s, 1);
    wr(A_STAT, 64'h0);
    rd(A_STAT, s);
    chk(s[58] == 1'b0 && s[59] == 1'b1, "R8 clear keeps full", s[63:56], 8'h08);
    clr_mon();
    wr(A_PROG, 64'h11_31_10_00_0000_0000);
    wait_idle();
    chk(mosi_cap[7:0] == 8'h11, "R7 write discarded", mosi_cap[7:0], 8'h11);
  endtask

  task automatic t_txstall();
    logic [63:0] s;
    clr_mon();
    wr(A_PROG, 64'h11_32_10_00_0000_0000);
    repeat (20) @(negedge clk);
    rd(A_STAT, s);
    chk(s[55:48] == 8'h04, "R5 stall state", s[55:48], 8'h04);
    chk(rise_cnt == 0 && sck == 1'b0, "R5 sck idle", rise_cnt, 0);
    chk(cs_n == 4'b1110, "R5 cs held", cs_n, 4'b1110);
    wr(A_TX, 64'hDEAD_000000000000);
    wait_idle();
    chk(mosi_cap[15:0] == 16'hDEAD && rise_cnt == 16, "R5 resume", mosi_cap[15:0], 16'hDEAD);
  endtask

  task automatic t_rxstall();
    logic [63:0] s;
    slv_sr = {8'hC3, 120'h0};
    wr(A_PROG, 64'h41_00_000000000000);
    wait_idle();
    slv_sr = {8'h7E, 120'h0};
    clr_mon();
    wr(A_PROG, 64'h41_00_000000000000);
    repeat (20) @(negedge clk);
    rd(A_STAT, s);
    chk(s[55:48] == 8'h10 && rise_cnt == 0, "R6 stall while full", s[55:48], 8'h10);
    rd(A_RX, s);
    chk(s == 64'hC3, "R6 first word", s, 64'hC3);
    wait_idle();
    rd(A_RX, s);
    chk(s == 64'h7E, "R6 second word", s, 64'h7E);
  endtask

  task automatic t_full8();
    logic [63:0] s;
    wr(A_TX, 64'h0123456789ABCDEF);
    slv_sr = {64'h0, 64'hFEDCBA9876543210};
    clr_mon();
    wr(A_PROG, 64'h11_38_48_10_00_000000);
    wait_idle();
    chk(mosi_cap[127:64] == 64'h0123456789ABCDEF, "R3 eight bytes out", mosi_cap[127:64], 64'h0123456789ABCDEF);
    rd(A_RX, s);
    chk(s == 64'hFEDCBA9876543210, "R4 eight bytes in", s, 64'hFEDCBA9876543210);
  endtask

  task automatic t_noop();
    wr(A_TX, 64'h3C_00000000000000);
    clr_mon();
    wr(A_PROG, 64'hC0_E5_30_49_11_31_10_07);
    wait_idle();
    chk(rise_cnt == 8 && mosi_cap[7:0] == 8'h3C, "R11 no-op opcodes", {rise_cnt, mosi_cap[7:0]}, {32'd8, 8'h3C});
    chk(cs_n == 4'hF, "R1 ends after eighth", cs_n, 4'hF);
  endtask

  task automatic t_busy();
    logic [63:0] s;
    wr(A_PROG, 64'h11_31_10_00_0000_0000);
    wr(A_PROG, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(A_PROG, s);
    chk(s == 64'h11_31_10_00_0000_0000, "R12 write ignored", s, 64'h1131100000000000);
    clr_mon();
    wr(A_TX, 64'h77_00000000000000);
    wait_idle();
    chk(mosi_cap[7:0] == 8'h77 && rise_cnt == 8, "R12 program intact", mosi_cap[7:0], 8'h77);
  endtask

  task automatic t_stop();
    logic [63:0] s;
    wr(A_TX, 64'h55_00000000000000);
    clr_mon();
    wr(A_PROG, 64'h11_00_31_10_0000_0000);
    wait_idle();
    rd(A_STAT, s);
    chk(s[59] == 1'b1 && rise_cnt == 0, "R1 stop opcode", {s[59], rise_cnt}, {1'b1, 32'd0});
    chk(cs_n == 4'b1110, "R2 stop keeps cs", cs_n, 4'b1110);
  endtask

  task automatic t_sreset();
    logic [63:0] s, cfg;
    wr(A_CLK, {12'd1, 52'h0});
    rd(A_CLK, cfg);
    wr(A_PROG, 64'h41_00_000000000000);
    wait_idle();
    wr(A_PROG, 64'h12_41_00_00000000_00);
    repeat (5) @(negedge clk);
    wr(A_CLK, 64'h0000_0050_0000_0000);
    rd(A_STAT, s);
    chk(s[55:48] == 8'h10 && cs_n == 4'b1101, "R10 first step alone", s[55:48], 8'h10);
    wr(A_CLK, 64'h0000_00A0_0000_0000);
    rd(A_STAT, s);
    chk(s == IDLE_ST, "R10 status after reset", s, IDLE_ST);
    chk(cs_n == 4'hF, "R10 cs released", cs_n, 4'hF);
    rd(A_CLK, s);
    chk(s == cfg, "R10 config kept", s, cfg);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tx();
    t_rx();
    t_ovr();
    t_txstall();
    t_rxstall();
    t_full8();
    t_noop();
    t_busy();
    t_stop();
    t_sreset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule